// File: doc/BRIEF.md
# Fractional UART baud-rate generator

This block produces the clock-enable pulse that a UART uses for 16x oversampling. A fractional pre-scaler runs first and thins the peripheral clock. An integer divisor counter follows it and divides the thinned stream down to one-cycle tick pulses. Three fields set the rate: a 16-bit integer divisor held as a low byte and a high byte, an add field and a multiply field. The tick rate is `clk / (DL × (1 + ADD/MUL))`, where DL = 256 × high + low. The baud rate is therefore that tick rate divided by 16.

Software sets the rate through a small register write port and can read the settings back on a separate read port. Any write restarts the fractional phase and the divisor count from zero, so a new setting takes effect from a known point. A combinational flag reports when the add and multiply fields hold an illegal pair. The tick output is not defined while that flag is set.

The fractional stage is a two-state machine. In `FS_BYPASS` every clock passes straight through to the divisor. In `FS_ACCUM` each clock adds MUL to an accumulator. When the sum reaches MUL+ADD, the stage emits an enable and subtracts MUL+ADD from the sum. Only a write to the fractional register moves the machine between its states. It takes `FS_BYPASS→FS_ACCUM` when the written add field is non-zero, and `FS_ACCUM→FS_BYPASS` (or stays in `FS_BYPASS`) when that field is zero. Reset puts it in `FS_BYPASS`.

Top module: `uart_frac_baudgen`

## Requirements
- R1: After reset, address 0 reads 1, address 1 reads 0, address 2 reads 0x10 (MUL=1, ADD=0), address 3 reads 0, the invalid flag is low and the tick is high on every clock.
- R2: With a legal setting, the count of enables after k clocks since the last write is floor(k×MUL/(MUL+ADD)). The tick is high in the clock after an enable that brings this count to a multiple of DL. Over a window of n clocks, the tick count stays within one of n×MUL/((MUL+ADD)×DL).
- R3: When ADD=0, the fractional stage is bypassed and the tick occurs exactly every DL clocks.
- R4: In the register at address 2, bits 3:0 hold ADD and bits 7:4 hold MUL. Bits 31:8 ignore writes and read as 0.
- R5: The invalid flag is high exactly when MUL=0, or ADD=15, or ADD≥MUL.
- R6: A divisor of 0 behaves as a divisor of 1.
- R7: Any write clears the accumulator and the divisor count. The tick is low in the clock that follows the write.
- R8: When the effective divisor is 2 or more, the tick is never high in two consecutive clocks.
- R9: Address 0 holds the low divisor byte and address 1 holds the high byte, each read back zero-extended. DL = 256 × high + low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low byte, 1 high byte, 2 fractional, 3 unused |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |
| tick16_o | output | 1 | One-cycle 16x oversampling enable |
| cfg_invalid_o | output | 1 | Illegal MUL/ADD pair |

## Verification
A wrong accumulator value or divisor count shifts the position of the very next tick. The bench compares the tick with an arithmetic model on every clock, so such a fault shows at most DL×(MUL+ADD)/MUL clocks after it occurs. A missed clear on write shows as a tick phase that is off in the first period after the write. A wrong state in the fractional machine changes the tick spacing of a bypass setting within a single period.

// File: rtl/ufb_pkg.sv
package ufb_pkg;
    typedef enum logic {
        FS_BYPASS = 1'b0,
        FS_ACCUM  = 1'b1
    } frac_state_e;
endpackage

// File: rtl/ufb_cfg_regs.sv
module ufb_cfg_regs #(
    parameter int DATA_W    = 32,
    parameter int BYTE_W    = 8,
    parameter int DIV_BYTES = 2,
    parameter int FW        = 4,
    parameter int ADDR_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic [DIV_BYTES*BYTE_W-1:0] dl_o,
    output logic [FW-1:0]               add_o,
    output logic [FW-1:0]               mul_o,
    output logic                        clr_o,
    output logic                        frac_wr_o,
    output logic                        invalid_o
);
    localparam int DIV_W     = DIV_BYTES * BYTE_W;
    localparam int FRAC_ADDR = DIV_BYTES;

    logic [BYTE_W-1:0] div_byte [DIV_BYTES];
    logic [FW-1:0]     add_q, mul_q;
    logic              unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:2*FW];

    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
        always_ff @(posedge clk) begin
            if (!rst_n)
                div_byte[b] <= (b == 0) ? BYTE_W'(1) : '0;
            else if (wr_en && wr_addr == ADDR_W'(b))
                div_byte[b] <= wr_data[BYTE_W-1:0];
        end
        assign dl_o[b*BYTE_W +: BYTE_W] = div_byte[b];
    end

    assign frac_wr_o = wr_en && (wr_addr == ADDR_W'(FRAC_ADDR));
    assign clr_o     = wr_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            add_q <= '0;
            mul_q <= FW'(1);
        end else if (frac_wr_o) begin
            add_q <= wr_data[FW-1:0];
            mul_q <= wr_data[2*FW-1:FW];
        end
    end

    assign add_o = add_q;
    assign mul_o = mul_q;
    assign invalid_o = (mul_q == '0) || (add_q == '1) || (add_q >= mul_q);

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(FRAC_ADDR))
            rd_data[2*FW-1:0] = {mul_q, add_q};
        else
            for (int b = 0; b < DIV_BYTES; b++)
                if (rd_addr == ADDR_W'(b))
                    rd_data[BYTE_W-1:0] = div_byte[b];
    end

    // R4
    frac_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frac_wr_o |=> (mul_q == $past(wr_data[2*FW-1:FW])) && (add_q == $past(wr_data[FW-1:0])));

    // R9
    div_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (dl_o[BYTE_W-1:0] == $past(wr_data[BYTE_W-1:0])));

    initial assert (DIV_W <= DATA_W);
endmodule

// File: rtl/ufb_frac_stage.sv
module ufb_frac_stage
    import ufb_pkg::*;
#(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          frac_wr_i,
    input  logic [FW-1:0] wr_add_i,
    input  logic [FW-1:0] add_i,
    input  logic [FW-1:0] mul_i,
    input  logic          invalid_i,
    output logic          en_o
);
    localparam int ACC_W = FW + 2;

    frac_state_e      state_q, state_d;
    logic [ACC_W-1:0] acc_q, acc_d, sum, modulus;

    assign modulus = ACC_W'(mul_i) + ACC_W'(add_i);
    assign sum     = acc_q + ACC_W'(mul_i);

    // state register: moves only on a fractional register write
    always_comb begin
        state_d = state_q;
        if (frac_wr_i)
            state_d = (wr_add_i == '0) ? FS_BYPASS : FS_ACCUM;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_BYPASS;
        else        state_q <= state_d;
    end

    // outputs and accumulator update
    always_comb begin
        en_o  = 1'b0;
        acc_d = '0;
        unique case (state_q)
            FS_BYPASS: begin
                en_o  = 1'b1;
                acc_d = '0;
            end
            FS_ACCUM: begin
                if (sum >= modulus) begin
                    en_o  = 1'b1;
                    acc_d = sum - modulus;
                end else begin
                    acc_d = sum;
                end
            end
            default: begin
                en_o  = 1'b0;
                acc_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) acc_q <= '0;
        else                 acc_q <= acc_d;
    end

    // R3
    state_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_BYPASS) |-> (add_i == '0));

    // R3
    bypass_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_BYPASS) |-> (acc_q == '0));

    // R2
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!invalid_i && state_q == FS_ACCUM) |-> (acc_q < modulus));

    // R7
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_q == '0));
endmodule

// File: rtl/ufb_int_divider.sv
module ufb_int_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [DIV_W-1:0] dl_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q, dl_eff;
    logic             last;

    assign dl_eff = (dl_i == '0) ? DIV_W'(1) : dl_i;
    assign last   = (cnt_q == dl_eff - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= en_i && last;
            if (en_i)
                cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
        end
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < dl_eff);

    // R7
    clr_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !tick_o);

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && dl_eff > DIV_W'(1)) |=> !tick_o);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(cnt_q) && !tick_o);
endmodule

// File: rtl/uart_frac_baudgen.sv
module uart_frac_baudgen #(
    parameter int DATA_W    = 32,
    parameter int BYTE_W    = 8,
    parameter int DIV_BYTES = 2,
    parameter int FW        = 4,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tick16_o,
    output logic              cfg_invalid_o
);
    localparam int DIV_W = DIV_BYTES * BYTE_W;

    logic [DIV_W-1:0] dl;
    logic [FW-1:0]    add_f, mul_f;
    logic             clr, frac_wr, frac_en;

    ufb_cfg_regs #(
        .DATA_W(DATA_W), .BYTE_W(BYTE_W), .DIV_BYTES(DIV_BYTES),
        .FW(FW), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .dl_o(dl), .add_o(add_f), .mul_o(mul_f),
        .clr_o(clr), .frac_wr_o(frac_wr), .invalid_o(cfg_invalid_o)
    );

    ufb_frac_stage #(.FW(FW)) u_frac (
        .clk(clk), .rst_n(rst_n),
        .clr_i(clr), .frac_wr_i(frac_wr), .wr_add_i(wr_data[FW-1:0]),
        .add_i(add_f), .mul_i(mul_f), .invalid_i(cfg_invalid_o),
        .en_o(frac_en)
    );

    ufb_int_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .clr_i(clr), .en_i(frac_en), .dl_i(dl),
        .tick_o(tick16_o)
    );

    // R1
    reset_tick_chk: assert property (@(posedge clk)
        !rst_n |=> !tick16_o);
endmodule

// File: tb/tb_uart_frac_baudgen.sv
module tb_uart_frac_baudgen;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    wire  [31:0] rd_data;
    wire         tick, inval;

    uart_frac_baudgen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick16_o(tick), .cfg_invalid_o(inval)
    );

    always #(CLK_NS/2) clk = ~clk;

    int checks = 0, errors = 0;
    int m_lo = 1, m_hi = 0, m_mul = 1, m_add = 0;
    int k = 0, ticks = 0;
    bit cmp_en = 1'b0, finished = 1'b0;

    // behavioural model state, advanced at the active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            k <= 0; m_lo <= 1; m_hi <= 0; m_mul <= 1; m_add <= 0;
        end else if (wr_en) begin
            k <= 0;
            case (wr_addr)
                2'd0: m_lo <= int'(wr_data[7:0]);
                2'd1: m_hi <= int'(wr_data[7:0]);
                2'd2: begin m_add <= int'(wr_data[3:0]); m_mul <= int'(wr_data[7:4]); end
                default: ;
            endcase
        end else k <= k + 1;
    end

    function automatic int dl_model();
        int d = m_hi * 256 + m_lo;
        return (d == 0) ? 1 : d;
    endfunction

    function automatic bit legal();
        return (m_mul >= 1) && (m_add <= 14) && (m_add < m_mul);
    endfunction

    function automatic int enables(int kk);
        return (kk * m_mul) / (m_mul + m_add);
    endfunction

    function automatic bit exp_tick();
        if (k == 0) return 1'b0;
        return (enables(k) != enables(k-1)) && (enables(k) % dl_model() == 0);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (tick) ticks++;
        if (cmp_en && rst_n && legal())
            check(tick == exp_tick(), "R2 R7 per-clock tick", int'(tick), int'(exp_tick()));
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(rd_data == 32'(exp), req, int'(rd_data), exp);
    endtask

    task automatic rate_chk(input int n, input string req);
        real expr;
        int meas;
        ticks = 0;
        repeat (n) @(negedge clk);
        #1;
        meas = ticks;
        expr = real'(n) * real'(m_mul) / (real'(m_mul + m_add) * real'(dl_model()));
        check((real'(meas) - expr <= 1.0) && (expr - real'(meas) <= 1.0), req, meas, int'(expr));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1 reset state
        rd_chk(2'd0, 1, "R1 low byte");
        rd_chk(2'd1, 0, "R1 high byte");
        rd_chk(2'd2, 32'h10, "R1 fractional reg");
        rd_chk(2'd3, 0, "R1 unused addr");
        check(inval == 1'b0, "R1 invalid flag", int'(inval), 0);
        rate_chk(40, "R1 tick every clock");

        // R4 reserved bits ignored, fields placed
        wr(2'd2, 32'hFFFF_FF52);
        rd_chk(2'd2, 32'h52, "R4 reserved bits read 0");
        wr(2'd0, 32'h0000_0003);
        check(tick == 1'b0, "R7 tick low after write", int'(tick), 0);
        rate_chk(3000, "R2 rate DL=3 MUL=5 ADD=2");

        // R3 bypass and R9 byte layout
        wr(2'd2, 32'h30);
        wr(2'd1, 32'hAB01);
        wr(2'd0, 32'h05);
        rd_chk(2'd1, 1, "R9 high byte zero-extended");
        rd_chk(2'd0, 5, "R9 low byte");
        ticks = 0;
        repeat (2610) @(negedge clk);
        #1;
        check(ticks == 10, "R3 bypass exact DL=261", ticks, 10);

        // R6 divisor zero
        wr(2'd1, 0);
        wr(2'd0, 0);
        rate_chk(400, "R6 divisor 0 as 1 bypass");
        wr(2'd2, 32'h41);
        rate_chk(500, "R6 divisor 0 MUL=4 ADD=1");

        // R2 more legal sets
        wr(2'd2, 32'hFE);
        wr(2'd0, 7);
        check(inval == 1'b0, "R5 MUL=15 ADD=14 legal", int'(inval), 0);
        rate_chk(4000, "R2 rate DL=7 MUL=15 ADD=14");
        wr(2'd2, 32'hD7);
        wr(2'd0, 2);
        rate_chk(3000, "R2 R8 rate DL=2 MUL=13 ADD=7");

        // R5 invalid pairs
        wr(2'd2, 32'h35);
        check(inval == 1'b1, "R5 ADD>=MUL", int'(inval), 1);
        wr(2'd2, 32'h05);
        check(inval == 1'b1, "R5 MUL=0", int'(inval), 1);
        wr(2'd2, 32'hFF);
        check(inval == 1'b1, "R5 ADD=15", int'(inval), 1);
        wr(2'd2, 32'h33);
        check(inval == 1'b1, "R5 ADD=MUL", int'(inval), 1);
        wr(2'd2, 32'h32);
        check(inval == 1'b0, "R5 MUL=3 ADD=2 legal", int'(inval), 0);
        wr(2'd0, 4);
        rate_chk(2000, "R2 rate after invalid DL=4 MUL=3 ADD=2");

        // R7 write restarts phase mid-period
        repeat (5) @(negedge clk);
        wr(2'd3, 32'h0);
        check(tick == 1'b0, "R7 tick low after unused-address write", int'(tick), 0);
        rate_chk(1000, "R7 R2 rate after restart");

        finish_run();
    end
endmodule